// File: doc/BRIEF.md
# Serial Port Register File with Combined Interrupt

This block is the software-visible front end of a serial port. A 32-bit register bus reaches a set of word registers through it. Whole characters arrive on a receive stream and leave on a transmit stream, each with a valid/ready handshake. The block holds three control words, a baud divider, a guard/prescale word and a receive-timeout word as plain storage. The shifter, baud generator and timers that use these values live elsewhere.

It owns the live status flags: receive-full, overrun, transmit-empty and transmit-done. It also implements the side effects of bus access on those flags: a write of 1 clears a flag, a receive-data read consumes the character, and a request register flushes the receive holding register. A single interrupt line is the OR of every status flag gated by its own enable bit. The overrun flag can be enabled by either of two bits.

Register map (byte offsets; the shifter side decodes these): 0x00 control A, 0x04 control B, 0x08 control C, 0x0C baud divider, 0x10 guard/prescale, 0x14 receive timeout, 0x18 request, 0x1C status, 0x20 flag clear, 0x24 receive data, 0x28 transmit data.

Status bits: bit 0 parity error, bit 1 framing error, bit 3 overrun, bit 4 idle, bit 5 receive-full, bit 6 transmit-done, bit 7 transmit-empty.

Control A bits: bit 0 port enable, bit 2 receive enable, bit 3 transmit enable, bit 4 idle interrupt enable, bit 5 receive interrupt enable, bit 6 done interrupt enable, bit 7 empty interrupt enable, bit 8 parity interrupt enable.

Control C bits: bit 0 error interrupt enable, bit 12 overrun disable.

Top module: `uart_rf`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except status, which reads 0x020000C0 (transmit-empty bit 7 and transmit-done bit 6 set). The interrupt and transmit valid are low.
- R2: Control A, B and C, guard/prescale and receive timeout read back exactly what was last written. The baud divider reads back only its low 16 bits.
- R3: A received character is taken (rx_ready high) but dropped with no flag or data change unless control A bit 0 and bit 2 are both set.
- R4: An accepted character is stored and sets receive-full (status bit 5). Reading 0x24 returns the low 9 bits and clears receive-full. If such a read coincides with an arriving character, the read returns the old character and the new one is stored with receive-full still set and no overrun.
- R5: With overrun-disable (control C bit 12) clear, a character arriving while receive-full is set is taken and discarded, sets overrun (status bit 3) and leaves the held data unchanged.
- R6: With overrun-disable set and the receiver enabled, rx_ready is low while receive-full is set.
- R7: Writing 0x28 stores the low 9 bits and clears transmit-empty. With control A bit 3 set, tx_valid rises and stays high until tx_ready, and transmit-empty stays low meanwhile. On the handshake, transmit-empty and transmit-done are both set. With bit 3 clear, nothing is sent and transmit-empty stays low.
- R8: Writing 0x20 clears each status bit written as 1. Writing 1 to bit 3 of 0x18 clears receive-full. A flag set by an event in the same cycle as its clear stays set. Reads of 0x18 and 0x20 return zero.
- R9: Writes to status (0x1C) and receive data (0x24) change nothing.
- R10: irq is combinationally the OR of: empty with A bit 7, done with A bit 6, receive-full with A bit 5, idle with A bit 4, parity error with A bit 8, overrun with (A bit 5 or C bit 0), and framing error with C bit 0.
- R11: Reads of unmapped offsets return zero with no side effect. Reading 0x28 returns the stored 9-bit transmit character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| rx_valid | input | 1 | Incoming character present |
| rx_ready | output | 1 | Incoming character is taken this cycle |
| rx_data | input | CHAR_W | Incoming character |
| tx_valid | output | 1 | Outgoing character present |
| tx_ready | input | 1 | Outgoing character is taken this cycle |
| tx_data | output | CHAR_W | Outgoing character |
| irq | output | 1 | Combined interrupt |

## Verification
The receive path is driven with a seeded random mix of incoming characters, receive-data reads, flushes, flag clears and changes to the enable and overrun-disable bits. After every step, status and the interrupt are compared against a bench model. This mix tells apart a dropped character, a stored one and an overrun, and it separates back-pressure from discard. Directed cases then cover what random traffic rarely reaches: a read that coincides with an arrival, a long transmit stall with tx_ready low, a transmit write with the transmitter off, and the overrun interrupt raised through the error enable alone. Writes to read-only offsets and reads of unmapped offsets are checked by reading back the state they could have disturbed.

// File: rtl/uart_rf_pkg.sv
// Shared constants for the serial port register file: word indices of the
// register map and bit positions of the fields the logic acts on.
package uart_rf_pkg;
    localparam int WIDX_CTLA  = 0;
    localparam int WIDX_CTLB  = 1;
    localparam int WIDX_CTLC  = 2;
    localparam int WIDX_BAUD  = 3;
    localparam int WIDX_GUARD = 4;
    localparam int WIDX_TMO   = 5;
    localparam int WIDX_REQ   = 6;
    localparam int WIDX_STAT  = 7;
    localparam int WIDX_CLR   = 8;
    localparam int WIDX_RXD   = 9;
    localparam int WIDX_TXD   = 10;
    localparam int NUM_CFG    = 6;   // plain storage words occupy indices 0..5

    // control A
    localparam int A_PORT_EN  = 0;
    localparam int A_RX_EN    = 2;
    localparam int A_TX_EN    = 3;
    localparam int A_IE_IDLE  = 4;
    localparam int A_IE_RXF   = 5;
    localparam int A_IE_DONE  = 6;
    localparam int A_IE_EMPTY = 7;
    localparam int A_IE_PAR   = 8;
    // control C
    localparam int C_IE_ERR   = 0;
    localparam int C_OVR_DIS  = 12;
    // request
    localparam int Q_RX_FLUSH = 3;
    // status
    localparam int S_PAR      = 0;
    localparam int S_FRM      = 1;
    localparam int S_OVR      = 3;
    localparam int S_IDLE     = 4;
    localparam int S_RXF      = 5;
    localparam int S_DONE     = 6;
    localparam int S_EMPTY    = 7;

    localparam logic [31:0] STAT_RESET = 32'h0200_00C0;
    // bits held by the live flag logic rather than the static status word
    localparam logic [31:0] LIVE_MASK  = (32'h1 << S_OVR) | (32'h1 << S_RXF) |
                                         (32'h1 << S_DONE) | (32'h1 << S_EMPTY);
endpackage

// File: rtl/uart_rf_cfg.sv
// Plain storage for the six configuration words. Each word is written whole
// when its index is selected; no field has any effect inside this block.
// Assumes the caller decodes the word index from the byte address.
module uart_rf_cfg #(
    parameter int SEL_W  = 4,
    parameter int NWORDS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [31:0]        wdata,
    output logic [31:0]        words [NWORDS]
);
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        // hold one configuration word, loaded on a write to its index
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                words[g] <= wdata;
        end
    end
endmodule

// File: rtl/uart_rf_rx.sv
// Receive holding register with receive-full and overrun flags.
// Assumes: clear requests come from bus side effects; an arrival in the same
// cycle as a clear is judged after the clear, so set wins.
module uart_rf_rx #(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              rx_en,
    input  logic              ovr_dis,
    input  logic              clr_full,
    input  logic              clr_ovr,
    output logic [CHAR_W-1:0] hold_q,
    output logic              full_q,
    output logic              ovr_q
);
    logic full_eff;
    logic take;
    logic store;
    logic ovr_set;

    // accept unless the receiver is on, full and back-pressure is selected
    assign rx_ready = !full_q || !ovr_dis || !rx_en;
    assign full_eff = full_q && !clr_full;
    assign take     = rx_valid && rx_ready;
    assign ovr_set  = take && rx_en && full_eff && !ovr_dis;
    assign store    = take && rx_en && !(full_eff && !ovr_dis);

    // update holding data and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (store)
                hold_q <= rx_data;
            if (store)
                full_q <= 1'b1;
            else if (clr_full)
                full_q <= 1'b0;
            if (ovr_set)
                ovr_q <= 1'b1;
            else if (clr_ovr)
                ovr_q <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rf_tx.sv
// Transmit holding register, output handshake and empty/done flags.
// Assumes a send is launched only by a data write made while the
// transmitter is enabled; a pending send is never withdrawn.
module uart_rf_tx #(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic              tx_en,
    input  logic              clr_empty,
    input  logic              clr_done,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              empty_q,
    output logic              done_q
);
    logic pend_q;
    logic sent;

    assign sent     = pend_q && tx_ready;
    assign tx_valid = pend_q;

    // hold the character and the pending handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= '0;
            pend_q  <= 1'b0;
        end else if (load) begin
            tx_data <= load_data;
            pend_q  <= tx_en || (pend_q && !tx_ready);
        end else if (sent) begin
            pend_q  <= 1'b0;
        end
    end

    // empty and done flags: completion sets, writes and clears drop them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            done_q  <= 1'b1;
        end else begin
            if (load)
                empty_q <= 1'b0;
            else if (sent)
                empty_q <= 1'b1;
            else if (clr_empty)
                empty_q <= 1'b0;
            if (sent)
                done_q <= 1'b1;
            else if (clr_done)
                done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rf_irq.sv
// Combined interrupt: OR of each status flag gated by its enable.
// Overrun may be enabled by either the receive or the error enable.
module uart_rf_irq (
    input  logic f_empty,
    input  logic f_done,
    input  logic f_rxf,
    input  logic f_idle,
    input  logic f_par,
    input  logic f_ovr,
    input  logic f_frm,
    input  logic e_empty,
    input  logic e_done,
    input  logic e_rxf,
    input  logic e_idle,
    input  logic e_par,
    input  logic e_err,
    output logic irq
);
    // gate and combine
    always_comb begin
        irq = (f_empty && e_empty) || (f_done && e_done) || (f_rxf && e_rxf) ||
              (f_idle && e_idle) || (f_par && e_par) ||
              (f_ovr && (e_rxf || e_err)) || (f_frm && e_err);
    end
endmodule

// File: rtl/uart_rf.sv
// Serial port register file. Decodes a 32-bit word bus, keeps configuration
// storage and status flags, applies access side effects and drives one
// combined interrupt. Assumes single-cycle accesses with read data returned
// combinationally; read side effects take place at the following edge.
module uart_rf
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CHAR_W = 9,
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CHAR_W-1:0] tx_data,
    output logic              irq
);
    localparam int SEL_W = ADDR_W - 2;

    logic [SEL_W-1:0]  sel;
    logic [31:0]       cfg_w [NUM_CFG];
    logic [31:0]       ctla, ctlc;
    logic [31:0]       stat_rest_q;
    logic [31:0]       stat_word;
    logic [CHAR_W-1:0] hold_q;
    logic              rx_full, overrun, tx_empty, tx_done;
    logic              wr_clr, wr_req, wr_txd, rd_rxd;
    logic              unused_addr_lsb;

    assign sel             = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign wr_clr = bus_wr && sel == SEL_W'(WIDX_CLR);
    assign wr_req = bus_wr && sel == SEL_W'(WIDX_REQ);
    assign wr_txd = bus_wr && sel == SEL_W'(WIDX_TXD);
    assign rd_rxd = bus_rd && sel == SEL_W'(WIDX_RXD);

    uart_rf_cfg #(.SEL_W(SEL_W), .NWORDS(NUM_CFG)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_sel(sel),
        .wdata(bus_wdata), .words(cfg_w)
    );
    assign ctla = cfg_w[WIDX_CTLA];
    assign ctlc = cfg_w[WIDX_CTLC];

    uart_rf_rx #(.CHAR_W(CHAR_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_en(ctla[A_PORT_EN] && ctla[A_RX_EN]),
        .ovr_dis(ctlc[C_OVR_DIS]),
        .clr_full(rd_rxd || (wr_req && bus_wdata[Q_RX_FLUSH]) ||
                  (wr_clr && bus_wdata[S_RXF])),
        .clr_ovr(wr_clr && bus_wdata[S_OVR]),
        .hold_q(hold_q), .full_q(rx_full), .ovr_q(overrun)
    );

    uart_rf_tx #(.CHAR_W(CHAR_W)) tx_i (
        .clk(clk), .rst_n(rst_n),
        .load(wr_txd), .load_data(bus_wdata[CHAR_W-1:0]),
        .tx_en(ctla[A_TX_EN]),
        .clr_empty(wr_clr && bus_wdata[S_EMPTY]),
        .clr_done(wr_clr && bus_wdata[S_DONE]),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .empty_q(tx_empty), .done_q(tx_done)
    );

    // static status bits: only reset sets them, flag-clear writes drop them
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_rest_q <= STAT_RESET & ~LIVE_MASK;
        else if (wr_clr)
            stat_rest_q <= stat_rest_q & ~bus_wdata;
    end

    // assemble the status word from static and live bits
    always_comb begin
        stat_word          = stat_rest_q & ~LIVE_MASK;
        stat_word[S_OVR]   = overrun;
        stat_word[S_RXF]   = rx_full;
        stat_word[S_DONE]  = tx_done;
        stat_word[S_EMPTY] = tx_empty;
    end

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel < SEL_W'(NUM_CFG)) begin
                bus_rdata = cfg_w[sel[$clog2(NUM_CFG)-1:0]];
                if (sel == SEL_W'(WIDX_BAUD))
                    bus_rdata = {{(32-BAUD_W){1'b0}}, cfg_w[WIDX_BAUD][BAUD_W-1:0]};
            end else if (sel == SEL_W'(WIDX_STAT)) begin
                bus_rdata = stat_word;
            end else if (sel == SEL_W'(WIDX_RXD)) begin
                bus_rdata = {{(32-CHAR_W){1'b0}}, hold_q};
            end else if (sel == SEL_W'(WIDX_TXD)) begin
                bus_rdata = {{(32-CHAR_W){1'b0}}, tx_data};
            end
        end
    end

    uart_rf_irq irq_i (
        .f_empty(stat_word[S_EMPTY]), .f_done(stat_word[S_DONE]),
        .f_rxf(stat_word[S_RXF]), .f_idle(stat_word[S_IDLE]),
        .f_par(stat_word[S_PAR]), .f_ovr(stat_word[S_OVR]),
        .f_frm(stat_word[S_FRM]),
        .e_empty(ctla[A_IE_EMPTY]), .e_done(ctla[A_IE_DONE]),
        .e_rxf(ctla[A_IE_RXF]), .e_idle(ctla[A_IE_IDLE]),
        .e_par(ctla[A_IE_PAR]), .e_err(ctlc[C_IE_ERR]),
        .irq(irq)
    );
endmodule

// File: rtl/uart_rf_chk.sv
// Protocol and flag checks for uart_rf, attached by bind.
module uart_rf_chk
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CHAR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              irq,
    input logic              rx_full,
    input logic              overrun,
    input logic              tx_empty,
    input logic              tx_done,
    input logic [31:0]       ctla,
    input logic [31:0]       ctlc,
    input logic [CHAR_W-1:0] hold_q
);
    logic [ADDR_W-3:0] s;
    logic              quiet;
    assign s     = bus_addr[ADDR_W-1:2];
    assign quiet = !bus_wr && !bus_rd;

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid);
    // R7
    tx_empty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !tx_empty);
    // R7
    tx_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && quiet |=> tx_empty && tx_done);
    // R6
    rx_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctla[A_PORT_EN] && ctla[A_RX_EN] && ctlc[C_OVR_DIS] && rx_full |-> !rx_ready);
    // R5
    rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && ctla[A_PORT_EN] && ctla[A_RX_EN] && rx_full &&
        !ctlc[C_OVR_DIS] && quiet |=> overrun && $stable(hold_q));
    // R3
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !(ctla[A_PORT_EN] && ctla[A_RX_EN]) && quiet
        |=> $stable(hold_q) && $stable(rx_full) && $stable(overrun));
    // R10
    irq_rxf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && ctla[A_IE_RXF] |-> irq);
    // R10
    irq_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && ctlc[C_IE_ERR] |-> irq);
    // R8
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (s == (ADDR_W-2)'(WIDX_CLR) || s == (ADDR_W-2)'(WIDX_REQ))
        |-> bus_rdata == 32'h0);
endmodule

bind uart_rf uart_rf_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq),
    .rx_full(rx_full), .overrun(overrun), .tx_empty(tx_empty),
    .tx_done(tx_done), .ctla(ctla), .ctlc(ctlc), .hold_q(hold_q)
);

// File: tb/uart_rf_tb_top.sv
// Bench for uart_rf: directed corner cases, then a seeded random receive mix
// checked against a bench model of the flags and the interrupt.
module uart_rf_tb_top;
    localparam int ADDR_W = 6;
    localparam int CHAR_W = 9;
    localparam logic [5:0] O_A = 6'h00, O_B = 6'h04, O_C = 6'h08, O_BAUD = 6'h0C,
        O_GUARD = 6'h10, O_TMO = 6'h14, O_REQ = 6'h18, O_STAT = 6'h1C,
        O_CLR = 6'h20, O_RXD = 6'h24, O_TXD = 6'h28;

    logic clk = 0, rst_n = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic rx_valid = 0, rx_ready;
    logic [CHAR_W-1:0] rx_data = '0, tx_data;
    logic tx_valid, tx_ready = 0, irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;
    logic acc;

    always #2 clk = ~clk;

    uart_rf #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(posedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic send(input logic [CHAR_W-1:0] d, output logic taken);
        @(negedge clk); rx_data = d; rx_valid = 1;
        #1 taken = rx_ready;
        @(posedge clk); #1 rx_valid = 0;
    endtask

    function automatic logic model_irq(input logic [31:0] a, input logic [31:0] c,
                                       input logic e, input logic dn,
                                       input logic f, input logic o);
        return (e && a[7]) || (dn && a[6]) || (f && a[5]) || (o && (a[5] || c[0]));
    endfunction

    function automatic logic [31:0] model_stat(input logic e, input logic dn,
                                               input logic f, input logic o);
        return 32'h0200_0000 | (32'(e) << 7) | (32'(dn) << 6) | (32'(f) << 5) | (32'(o) << 3);
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        rd(O_STAT, rv); chk("R1 status", rv, 32'h0200_00C0);
        for (int i = 0; i < 11; i++) begin
            if (i != 7) begin
                rd(6'(i * 4), rv); chk("R1 register zero", rv, 0);
            end
        end

        // R2 storage readback
        wr(O_A, 32'h1234_5670); wr(O_B, 32'hDEAD_BEEF); wr(O_C, 32'h0BAD_F00D);
        wr(O_BAUD, 32'hABCD_1234); wr(O_GUARD, 32'h0000_A55A); wr(O_TMO, 32'hFF00_0FF0);
        rd(O_A, rv);     chk("R2 control A", rv, 32'h1234_5670);
        rd(O_B, rv);     chk("R2 control B", rv, 32'hDEAD_BEEF);
        rd(O_C, rv);     chk("R2 control C", rv, 32'h0BAD_F00D);
        rd(O_BAUD, rv);  chk("R2 baud low half", rv, 32'h0000_1234);
        rd(O_GUARD, rv); chk("R2 guard", rv, 32'h0000_A55A);
        rd(O_TMO, rv);   chk("R2 timeout", rv, 32'hFF00_0FF0);

        // R3 receiver gated by both enables
        do_reset();
        wr(O_A, 32'h4);
        send(9'h099, acc); chk("R3 taken while off", 32'(acc), 1);
        wr(O_A, 32'h1);
        send(9'h09A, acc); chk("R3 taken while off", 32'(acc), 1);
        rd(O_STAT, rv); chk("R3 no flag change", rv, 32'h0200_00C0);
        rd(O_RXD, rv);  chk("R3 data unchanged", rv, 0);

        // R4 store, read, simultaneous read and arrival
        wr(O_A, 32'h5);
        send(9'h1A5, acc);
        rd(O_STAT, rv); chk("R4 full set", rv, 32'h0200_00E0);
        rd(O_RXD, rv);  chk("R4 data", rv, 32'h1A5);
        rd(O_STAT, rv); chk("R4 full cleared by read", rv, 32'h0200_00C0);
        send(9'h011, acc);
        @(negedge clk); rx_data = 9'h022; rx_valid = 1; bus_addr = O_RXD; bus_rd = 1;
        #1 chk("R4 read with arrival old data", bus_rdata, 32'h011);
        @(posedge clk); #1 rx_valid = 0; bus_rd = 0;
        rd(O_STAT, rv); chk("R4 no false overrun", rv, 32'h0200_00E0);
        // R5 overrun keeps held data
        send(9'h033, acc); chk("R5 taken", 32'(acc), 1);
        rd(O_STAT, rv); chk("R5 overrun set", rv, 32'h0200_00E8);
        rd(O_RXD, rv);  chk("R5 data kept", rv, 32'h022);
        // R8 clear overrun
        wr(O_CLR, 32'h8);
        rd(O_STAT, rv); chk("R8 overrun cleared", rv, 32'h0200_00C0);

        // R6 back-pressure
        wr(O_C, 32'h1000);
        send(9'h055, acc);
        @(negedge clk); rx_data = 9'h066; rx_valid = 1;
        #1 chk("R6 ready low", 32'(rx_ready), 0);
        @(posedge clk); @(negedge clk);
        #1 chk("R6 ready still low", 32'(rx_ready), 0);
        rx_valid = 0;
        rd(O_STAT, rv); chk("R6 no overrun", rv, 32'h0200_00E0);
        rd(O_RXD, rv);  chk("R6 data", rv, 32'h055);
        #1 chk("R6 ready after read", 32'(rx_ready), 1);

        // R8 flush, read-zero, static bit clear
        send(9'h012, acc);
        wr(O_REQ, 32'h8);
        rd(O_STAT, rv); chk("R8 flush", rv, 32'h0200_00C0);
        rd(O_REQ, rv);  chk("R8 request reads zero", rv, 0);
        rd(O_CLR, rv);  chk("R8 clear reads zero", rv, 0);
        wr(O_CLR, 32'h0200_0000);
        rd(O_STAT, rv); chk("R8 static bit clear", rv, 32'h0000_00C0);

        // R9 ignored writes
        do_reset();
        wr(O_STAT, 32'hFFFF_FFFF);
        rd(O_STAT, rv); chk("R9 status write ignored", rv, 32'h0200_00C0);
        wr(O_A, 32'h5);
        send(9'h1AB, acc);
        wr(O_RXD, 32'h0);
        rd(O_RXD, rv);  chk("R9 data write ignored", rv, 32'h1AB);

        // R11 unmapped reads
        send(9'h007, acc);
        rd(6'h2C, rv); chk("R11 unmapped zero", rv, 0);
        rd(6'h3C, rv); chk("R11 unmapped zero", rv, 0);
        rd(O_STAT, rv); chk("R11 no side effect", rv, 32'h0200_00E0);

        // R7 transmit
        do_reset();
        wr(O_A, 32'h8);
        wr(O_CLR, 32'hC0);
        wr(O_TXD, 32'h0000_03C7);
        chk("R7 valid raised", 32'(tx_valid), 1);
        chk("R7 data", 32'(tx_data), 32'h1C7);
        repeat (3) @(posedge clk);
        #1 chk("R7 valid held", 32'(tx_valid), 1);
        rd(O_STAT, rv); chk("R7 empty low while waiting", rv, 32'h0200_0000);
        @(negedge clk); tx_ready = 1;
        @(posedge clk); #1 chk("R7 valid dropped", 32'(tx_valid), 0);
        tx_ready = 0;
        rd(O_STAT, rv); chk("R7 empty and done set", rv, 32'h0200_00C0);
        rd(O_TXD, rv);  chk("R11 transmit readback", rv, 32'h1C7);
        wr(O_A, 32'h0);
        wr(O_TXD, 32'h55);
        repeat (2) @(posedge clk);
        #1 chk("R7 no send when disabled", 32'(tx_valid), 0);
        rd(O_STAT, rv); chk("R7 empty stays low", rv, 32'h0200_0040);

        // R10 interrupt pairs
        do_reset();
        wr(O_A, 32'h80); chk("R10 empty enable", 32'(irq), 1);
        wr(O_A, 32'h40); chk("R10 done enable", 32'(irq), 1);
        wr(O_A, 32'h05); chk("R10 no enable", 32'(irq), 0);
        send(9'h1, acc); send(9'h2, acc);
        chk("R10 flags without enable", 32'(irq), 0);
        wr(O_C, 32'h1);  chk("R10 overrun via error enable", 32'(irq), 1);
        wr(O_C, 32'h0);  chk("R10 overrun disabled", 32'(irq), 0);
        wr(O_A, 32'h25); chk("R10 receive enable", 32'(irq), 1);

        // random receive mix against the model
        do_reset();
        begin
            logic [31:0] ma, mc;
            logic me, md, mf, mo;
            logic [CHAR_W-1:0] mh;
            ma = 0; mc = 0; me = 1; md = 1; mf = 0; mo = 0; mh = 0;
            void'($urandom(32'd2024));
            for (int it = 0; it < 300; it++) begin
                int op;
                logic [31:0] v;
                op = $urandom % 7;
                case (op)
                    0, 1: begin
                        logic [CHAR_W-1:0] d;
                        logic en, exp_rdy;
                        d = CHAR_W'($urandom);
                        en = ma[0] && ma[2];
                        exp_rdy = !mf || !mc[12] || !en;
                        send(d, acc);
                        chk("R6 random ready", 32'(acc), 32'(exp_rdy));
                        if (exp_rdy && en) begin
                            if (mf && !mc[12]) mo = 1;
                            else begin mh = d; mf = 1; end
                        end
                    end
                    2: begin
                        rd(O_RXD, v); chk("R4 random data", v, 32'(mh)); mf = 0;
                    end
                    3: begin
                        v = ($urandom & 32'h1F0) | (($urandom % 4 != 0) ? 32'h5 : 32'h0);
                        wr(O_A, v); ma = v;
                    end
                    4: begin
                        v = $urandom & 32'h1001; wr(O_C, v); mc = v;
                    end
                    5: begin
                        v = $urandom & 32'hE8; wr(O_CLR, v);
                        if (v[3]) mo = 0;
                        if (v[5]) mf = 0;
                        if (v[6]) md = 0;
                        if (v[7]) me = 0;
                    end
                    default: begin
                        v = $urandom & 32'h8; wr(O_REQ, v);
                        if (v[3]) mf = 0;
                    end
                endcase
                rd(O_STAT, v);
                chk("R8 random status", v, model_stat(me, md, mf, mo));
                chk("R10 random irq", 32'(irq), 32'(model_irq(ma, mc, me, md, mf, mo)));
            end
        end
        summary();
    end
endmodule